// File: doc/BRIEF.md
# Privileged Split-Half Time Base Counter

This block holds a free-running 64-bit up-counter. It advances by one on every clock cycle in which the tick enable is high. An external divider produces that enable from the processor clock, and the same divider also serves the decrementer. Software sees the count as two 32-bit words, an upper word and a lower word. Any privilege level may read either word. Writes are accepted only when a supervisor qualifier accompanies the strobe. Each write targets exactly one word, so loading the full 64-bit value always takes two separate accesses.

A one-bit access select picks the word. Select 0 is the lower word and select 1 is the upper word. The same select steers writes and chooses which word appears on the read-data port. Both words are also driven out in full for hardware consumers.

Reset does not clear the count. While reset is asserted the block ignores ticks and writes, so a value written before reset survives it unchanged. Software is expected to initialise the count after power-up.

Top module: `timebase64`

## Requirements
- R1: With reset released, the tick enable high and no accepted write, the 64-bit value {upper, lower} increases by exactly one at the clock edge. With the tick enable low and no accepted write, both words hold.
- R2: A tick that finds the lower word all ones sets the lower word to zero and adds one to the upper word at the same edge. A tick at the all-ones 64-bit value wraps both words to zero.
- R3: A write with the write strobe high, the supervisor qualifier high and access select 0 loads the write data into the lower word at the clock edge. The upper word keeps its value.
- R4: A write with the write strobe high, the supervisor qualifier high and access select 1 loads the write data into the upper word at the clock edge. The lower word keeps its value.
- R5: A write with the supervisor qualifier low is ignored. Both words keep their values, or only advance by the tick if one occurs in the same cycle.
- R6: When an accepted write coincides with a tick, the written word takes the write data. The other word still takes the tick's effect, and any carry out of the old lower word is included in that effect.
- R7: While the active-low reset is asserted, ticks and writes have no effect. Asserting reset never changes the count.
- R8: The read-data port shows the lower word when access select is 0 and the upper word when it is 1, at any privilege level, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low reset; gates activity, keeps the count |
| tickEn | input | 1 | Count enable from the external clock divider |
| wrEn | input | 1 | Write strobe for one word |
| accSel | input | 1 | Word select: 0 lower, 1 upper |
| supervisor | input | 1 | High when the access has supervisor privilege |
| wrData | input | HALF_W | Data for the selected word |
| rdData | output | HALF_W | Selected word, combinational |
| cntLo | output | HALF_W | Lower word of the count |
| cntHi | output | HALF_W | Upper word of the count |

## Verification
A broken carry path first shows up as a wrong upper word in the cycle after the lower word passes all ones. If the carry is lost, the upper word stalls. If it is spurious, the upper word jumps one cycle early. A privilege or select decoding fault changes a word one cycle after the offending strobe, so a denied write or a write to the wrong word is visible at the ports on the very next sample. Reset gating faults show up as motion of the count during the reset window.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Word select encoding shared by control and checker
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;

  // Number of separately addressable words in the counter
  localparam int NUM_WORDS = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;    // advance the count this cycle
    logic loadLo;  // replace lower word with write data
    logic loadHi;  // replace upper word with write data
  } tbStrobe_t;

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      wrEn,
  input  logic      accSel,
  input  logic      supervisor,
  output tbStrobe_t strb
);

  logic accepted;

  // A write is accepted only outside reset and with supervisor privilege
  assign accepted = rstN && wrEn && supervisor;

  always_comb begin
    strb        = '0;
    strb.tick   = rstN && tickEn;
    strb.loadLo = accepted && (accSel == SEL_LO);
    strb.loadHi = accepted && (accSel == SEL_HI);
  end

endmodule

// File: rtl/tbase_datapath.sv
module tbase_datapath
  import tbase_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  tbStrobe_t         strb,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi
);

  localparam int NW = NUM_WORDS;

  logic [NW-1:0]             load;
  logic [NW:0]               carry;
  logic [NW-1:0][HALF_W-1:0] word;

  assign load[0]  = strb.loadLo;
  assign load[1]  = strb.loadHi;
  assign carry[0] = strb.tick;

  // One register per word; carry ripples from each word's old value
  for (genvar i = 0; i < NW; i++) begin : g_word
    assign carry[i+1] = carry[i] && (word[i] == {HALF_W{1'b1}});

    always_ff @(posedge clk) begin
      if (load[i]) begin
        word[i] <= wrData;
      end else if (carry[i]) begin
        word[i] <= word[i] + {{(HALF_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign cntLo = word[0];
  assign cntHi = word[1];

endmodule

// File: rtl/timebase64.sv
module timebase64
  import tbase_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              accSel,
  input  logic              supervisor,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi
);

  tbStrobe_t strb;

  tbase_ctrl u_ctrl (
    .rstN       (rstN),
    .tickEn     (tickEn),
    .wrEn       (wrEn),
    .accSel     (accSel),
    .supervisor (supervisor),
    .strb       (strb)
  );

  tbase_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk    (clk),
    .strb   (strb),
    .wrData (wrData),
    .cntLo  (cntLo),
    .cntHi  (cntHi)
  );

  // Reads need no privilege and no clock
  assign rdData = (accSel == SEL_HI) ? cntHi : cntLo;

endmodule

// File: rtl/tbase_checker.sv
module tbase_checker
  import tbase_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic              accSel,
  input logic              supervisor,
  input logic [HALF_W-1:0] wrData,
  input logic [HALF_W-1:0] cntLo,
  input logic [HALF_W-1:0] cntHi
);

  localparam logic [HALF_W-1:0] ONES = {HALF_W{1'b1}};
  localparam logic [HALF_W-1:0] ONE  = {{(HALF_W-1){1'b0}}, 1'b1};

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  logic okWrite;
  assign okWrite = wrEn && supervisor;

  // R1
  a_r1_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrEn) |=> ({cntHi, cntLo} == $past({cntHi, cntLo}) + 1'b1));

  // R2
  a_r2_carry_same_edge: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrEn && cntLo == ONES) |=> (cntLo == '0 && cntHi == $past(cntHi) + ONE));

  // R3
  a_r3_load_lower: assert property (@(posedge clk) disable iff (!rstN)
    (okWrite && accSel == SEL_LO && !tickEn) |=> (cntLo == $past(wrData) && $stable(cntHi)));

  // R4
  a_r4_load_upper: assert property (@(posedge clk) disable iff (!rstN)
    (okWrite && accSel == SEL_HI && !tickEn) |=> (cntHi == $past(wrData) && $stable(cntLo)));

  // R5
  a_r5_user_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !supervisor && !tickEn) |=> ($stable(cntLo) && $stable(cntHi)));

  // R6
  a_r6_carry_survives_load: assert property (@(posedge clk) disable iff (!rstN)
    (okWrite && accSel == SEL_LO && tickEn && cntLo == ONES)
      |=> (cntLo == $past(wrData) && cntHi == $past(cntHi) + ONE));

  // R7
  a_r7_reset_freezes: assert property (@(posedge clk)
    (pastValid && !rstN) |=> ($stable(cntLo) && $stable(cntHi)));

endmodule

bind timebase64 tbase_checker #(.HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .wrEn       (wrEn),
  .accSel     (accSel),
  .supervisor (supervisor),
  .wrData     (wrData),
  .cntLo      (cntLo),
  .cntHi      (cntHi)
);

// File: tb/timebase64_bench.sv
`timescale 1ns/1ps
module timebase64_bench;

  localparam int HW = 4;
  localparam int FW = 2 * HW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic          wrEn = 1'b0;
  logic          accSel = 1'b0;
  logic          supervisor = 1'b0;
  logic [HW-1:0] wrData = '0;
  logic [HW-1:0] rdData, cntLo, cntHi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timebase64 #(.HALF_W(HW)) u_timebase64 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .accSel(accSel),
    .supervisor(supervisor), .wrData(wrData), .rdData(rdData),
    .cntLo(cntLo), .cntHi(cntHi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic cyc(input bit t, input bit w, input bit s, input bit sup,
                     input int d);
    @(negedge clk);
    tickEn = t; wrEn = w; accSel = s; supervisor = sup; wrData = d[HW-1:0];
    @(posedge clk);
    #1;
  endtask

  function automatic int full();
    return {cntHi, cntLo};
  endfunction

  task automatic setFull(input int v);
    cyc(0, 1, 0, 1, v % 16);
    cyc(0, 1, 1, 1, v / 16);
  endtask

  initial begin
    repeat (3) cyc(0, 0, 0, 0, 0);
    rstN = 1'b1;

    // R3, R4, R1, R2, R8: sweep every starting value
    for (int v = 0; v < (1 << FW); v++) begin
      cyc(0, 1, 0, 1, v % 16);
      check("R3 lower load", cntLo, v % 16);
      cyc(0, 1, 1, 1, v / 16);
      check("R4 upper load", cntHi, v / 16);
      check("R3 lower kept by upper load", cntLo, v % 16);
      check("R8 read upper", rdData, v / 16);
      cyc(1, 0, 0, 0, 0);
      check("R1 R2 tick", full(), (v + 1) % (1 << FW));
      check("R8 read lower", rdData, ((v + 1) % (1 << FW)) % 16);
    end

    // R1 hold without tick
    setFull(8'h5A);
    cyc(0, 0, 0, 0, 0);
    check("R1 hold no tick", full(), 8'h5A);

    // R4 lower unchanged by upper load
    setFull(8'h37);
    cyc(0, 1, 1, 1, 4'h9);
    check("R4 lower kept", full(), 8'h97);

    // R5 user writes ignored, both selects, with and without tick
    for (int s = 0; s < 2; s++) begin
      setFull(8'h3C);
      cyc(0, 1, s[0], 0, 4'hF);
      check("R5 user write ignored", full(), 8'h3C);
      cyc(1, 1, s[0], 0, 4'h0);
      check("R5 user write with tick", full(), 8'h3D);
    end

    // R6 write coincident with tick
    setFull(8'h2F);
    cyc(1, 1, 0, 1, 4'h6);
    check("R6 lower load plus carry", full(), 8'h36);
    setFull(8'h2F);
    cyc(1, 1, 1, 1, 4'hA);
    check("R6 upper load wins over carry", full(), 8'hA0);
    setFull(8'h25);
    cyc(1, 1, 1, 1, 4'h1);
    check("R6 upper load lower ticks", full(), 8'h16);

    // R2 full wrap
    setFull(8'hFF);
    cyc(1, 0, 0, 0, 0);
    check("R2 wrap to zero", full(), 0);

    // R7 reset freezes count and ignores activity
    setFull(8'hC4);
    rstN = 1'b0;
    cyc(1, 1, 0, 1, 4'h0);
    cyc(1, 1, 1, 1, 4'h0);
    cyc(1, 0, 0, 0, 0);
    check("R7 reset keeps count", full(), 8'hC4);
    rstN = 1'b1;
    cyc(1, 0, 1, 0, 0);
    check("R7 counts after reset", full(), 8'hC5);
    check("R8 read upper user", rdData, 4'hC);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule